// File: doc/BRIEF.md
# Character Sequence Recognizer

This block is a synchronous Moore state machine. It takes one 2-bit character per clock cycle, drawn from the four-letter alphabet a, b, c and d, and it accepts a character only when a valid strobe is high. It throws away every character up to and including the first "b". It then waits for a second "b", any number of "a" characters (zero or more), and a "d". When that pattern completes, the block raises a match output.

The 2-bit state register is brought out to a port so that the surrounding logic can observe it. If a character has no transition defined for the current state, the state stays where it is; the machine does not restart. Once a match has been found, the machine stays in the matched state until a synchronous reset.

Top module: `seqrec_top`

## Requirements
- R1: The character codes are a=2'b00, b=2'b01, c=2'b10 and d=2'b11.
- R2: While the active-high synchronous reset `rst` is sampled high, the state becomes 2'b00 on the next rising edge and `hit` becomes 0.
- R3: On a clock edge where `sym_valid` is low, the state and `hit` do not change, whatever the value on `sym_code`.
- R4: In state 2'b00 (idle), a valid "b" moves the state to 2'b01. A valid "a", "c" or "d" leaves the state at 2'b00.
- R5: In state 2'b01 (armed), a valid "b" moves the state to 2'b10. A valid "a", "c" or "d" leaves the state at 2'b01.
- R6: In state 2'b10 (collecting), a valid "d" moves the state to 2'b11. A valid "a", "b" or "c" leaves the state at 2'b10.
- R7: `hit` is high exactly when the state is 2'b11. It rises on the same edge on which the state enters 2'b11, which is one clock after the "d" is presented.
- R8: In state 2'b11, every input keeps the state at 2'b11 until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Marks the character on `sym_code` as valid in this cycle |
| sym_code | input | 2 | Character code (a=00, b=01, c=10, d=11) |
| hit | output | 1 | Match flag, high while the state is 2'b11 |
| state_obs | output | 2 | Current state, for observation |

## Verification
The state is visible at a port, so a wrong transition shows on `state_obs` on the very edge at which the character is accepted. The bench compares that value after every single step.

A wrong `hit` appears in the same cycle as the state change. Because the matched state holds until reset, a missed or false match stays visible until the bench next pulses reset. Random streams are broken up by frequent resets, which sends the machine through all four states many times.

// File: rtl/seqrec_pkg.sv
package seqrec_pkg;

    localparam int unsigned SYM_W = 2;
    localparam int unsigned ST_W  = 2;

    typedef enum logic [SYM_W-1:0] {
        SYM_A = 2'b00,
        SYM_B = 2'b01,
        SYM_C = 2'b10,
        SYM_D = 2'b11
    } sym_e;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_RUN   = 2'b10,
        ST_HIT   = 2'b11
    } st_e;

    typedef struct packed {
        st_e  st;
        logic hit;
    } regs_t;

endpackage

// File: rtl/seqrec_decode.sv
module seqrec_decode
    import seqrec_pkg::*;
(
    input  logic             valid,
    input  logic [SYM_W-1:0] code,
    output logic             take_b,
    output logic             take_d
);
    always_comb begin
        take_b = 1'b0;
        take_d = 1'b0;
        if (valid) begin
            case (sym_e'(code))
                SYM_B:   take_b = 1'b1;
                SYM_D:   take_d = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/seqrec_next.sv
module seqrec_next
    import seqrec_pkg::*;
(
    input  st_e  cur,
    input  logic take_b,
    input  logic take_d,
    output st_e  nxt
);
    // Anything without a listed transition keeps the current state.
    always_comb begin
        nxt = cur;
        case (cur)
            ST_IDLE:  if (take_b) nxt = ST_ARMED;
            ST_ARMED: if (take_b) nxt = ST_RUN;
            ST_RUN:   if (take_d) nxt = ST_HIT;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/seqrec_top.sv
module seqrec_top
    import seqrec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_code,
    output logic             hit,
    output logic [ST_W-1:0]  state_obs
);
    regs_t r_q, r_d;
    logic  take_b, take_d;
    st_e   st_nxt;

    seqrec_decode u_dec (
        .valid  (sym_valid),
        .code   (sym_code),
        .take_b (take_b),
        .take_d (take_d)
    );

    seqrec_next u_nxt (
        .cur    (r_q.st),
        .take_b (take_b),
        .take_d (take_d),
        .nxt    (st_nxt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.st  = st_nxt;
        r_d.hit = (st_nxt == ST_HIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, hit: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hit       = r_q.hit;
    assign state_obs = r_q.st;
endmodule

// File: rtl/seqrec_checker.sv
module seqrec_checker (
    input logic       clk,
    input logic       rst,
    input logic       sym_valid,
    input logic [1:0] sym_code,
    input logic       hit,
    input logic [1:0] state_obs
);
    a_r2_reset_idle: assert property (@(posedge clk)
        rst |=> (state_obs == 2'b00 && !hit));

    a_r3_hold_invalid: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> ($stable(state_obs) && $stable(hit)));

    a_r4_idle_b: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && state_obs == 2'b00 && sym_code == 2'b01) |=> state_obs == 2'b01);

    a_r5_armed_b: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && state_obs == 2'b01 && sym_code == 2'b01) |=> state_obs == 2'b10);

    a_r6_run_nond: assert property (@(posedge clk) disable iff (rst)
        (state_obs == 2'b10 && !(sym_valid && sym_code == 2'b11)) |=> state_obs == 2'b10);

    a_r7_d_hits: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && state_obs == 2'b10 && sym_code == 2'b11) |=> (hit && state_obs == 2'b11));

    a_r8_hit_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_obs == 2'b11) |=> (state_obs == 2'b11 && hit));
endmodule

bind seqrec_top seqrec_checker u_seqrec_checker (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_code  (sym_code),
    .hit       (hit),
    .state_obs (state_obs)
);

// File: tb/test_seqrec_top.sv
`timescale 1ns/1ps
module test_seqrec_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       sym_valid;
    logic [1:0] sym_code;
    logic       hit;
    logic [1:0] state_obs;

    int total = 0;
    int bad   = 0;
    logic [1:0] exp_st;

    always #2 clk = ~clk;

    seqrec_top i_seqrec_top (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .sym_code  (sym_code),
        .hit       (hit),
        .state_obs (state_obs)
    );

    // Reference model built from R4-R6 and R8; R1 supplies the codes.
    function automatic logic [1:0] model_next(input logic [1:0] s, input logic v, input logic [1:0] c);
        if (!v) return s;
        case (s)
            2'b00: return (c == 2'b01) ? 2'b01 : 2'b00;
            2'b01: return (c == 2'b01) ? 2'b10 : 2'b01;
            2'b10: return (c == 2'b11) ? 2'b11 : 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one character at the falling edge, let one rising edge pass, and compare at the next falling edge.
    task automatic step(input logic r, input logic v, input logic [1:0] c, input string req);
        sym_valid = v;
        sym_code  = c;
        rst       = r;
        @(posedge clk);
        exp_st = r ? 2'b00 : model_next(exp_st, v, c);
        @(negedge clk);
        check({req, " state"}, state_obs, exp_st);
        check({req, " hit (R7)"}, {1'b0, hit}, {1'b0, exp_st == 2'b11});
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        exp_st    = 2'b00;
        rst       = 1'b1;
        sym_valid = 1'b0;
        sym_code  = 2'b00;
        @(negedge clk);

        // R2: reset state.
        step(1'b1, 1'b1, 2'b01, "R2");

        // R1 and R4: a, c and d are discarded, then the first b arms the machine.
        step(1'b0, 1'b1, 2'b00, "R4");
        step(1'b0, 1'b1, 2'b10, "R4");
        step(1'b0, 1'b1, 2'b11, "R4");
        step(1'b0, 1'b1, 2'b01, "R4");
        check("R1 armed code", state_obs, 2'b01);

        // R5: a, c and d hold; b advances.
        step(1'b0, 1'b1, 2'b11, "R5");
        step(1'b0, 1'b1, 2'b00, "R5");
        step(1'b0, 1'b1, 2'b01, "R5");
        check("R1 run code", state_obs, 2'b10);

        // R6: c in the collecting state holds it.
        step(1'b0, 1'b1, 2'b10, "R6 c hold");

        // R3: a d with valid low is ignored.
        step(1'b0, 1'b0, 2'b11, "R3");
        check("R3 still run", state_obs, 2'b10);

        // R7: "bd" gives a match.
        step(1'b0, 1'b1, 2'b11, "R7 bd");
        check("R7 bd hit", {1'b0, hit}, 2'b01);

        // R8: every input keeps the matched state.
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, k[1:0], "R8");

        // R7: "baaad" after the first b gives a match.
        step(1'b1, 1'b0, 2'b00, "R2");
        step(1'b0, 1'b1, 2'b01, "R4");
        step(1'b0, 1'b1, 2'b01, "R5");
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 2'b00, "R6 a");
        check("R7 pre-d no hit", {1'b0, hit}, 2'b00);
        step(1'b0, 1'b1, 2'b11, "R7 baaad");
        check("R7 baaad hit", {1'b0, hit}, 2'b01);

        // Random streams, with frequent resets, across R2-R8.
        for (int n = 0; n < 3000; n++) begin
            logic r;
            logic v;
            logic [1:0] c;
            r = ($urandom % 16) == 0;
            v = ($urandom % 4) != 0;
            // Bias the characters toward b and d so that all states are reached.
            case ($urandom % 6)
                0: c = 2'b00;
                1: c = 2'b10;
                2, 3: c = 2'b01;
                default: c = 2'b11;
            endcase
            step(r, v, c, "R3-R8 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule